// File: doc/BRIEF.md
# System Control Coprocessor Register File

This block sits beside a 32-bit CPU core and holds its system-control state. The core addresses it with a register number and an operation code. Register 0 holds two fixed words supplied by parameters: an identification word and a cache-type word. Registers 1 to 4 hold the system control word, the page table base, the data fault status and the fault address. Register 5 and register 6 hold no data. A write to either one is decoded into a single-cycle cache-maintenance command or a TLB flush-all command, and the cache or TLB logic outside this block carries the command out.

Reads are combinational. Read data follows the register number, the operation code and the read enable in the same cycle. Writes and command pulses take effect at the clock edge. Any access the block does not recognise changes no state and raises a one-cycle error pulse. A small gate also decides whether a hardware interrupt request may be taken, based on the interrupt-disable bit of the core's status word.

Every access completes in one cycle. There is no valid/ready handshake and no back-pressure: an enable held for one cycle is one access. The core must never assert the read enable and the write enable in the same cycle.

Top module: `ctlcop_regfile`

## Requirements
- R1: After synchronous reset, registers 1 to 4 read as zero, and no command pulse and no error pulse is active.
- R2: A write to register 1, 2, 3 or 4 with operation code 0 stores the write data at the clock edge. A later read of that register with operation code 0 returns the stored word.
- R3: A write to registers 1 to 4 with a nonzero operation code leaves every stored word unchanged. A read of registers 1 to 4 with a nonzero operation code returns zero.
- R4: A read of register 0 with operation code 0 returns the identification parameter, and with operation code 1 it returns the cache-type parameter. A write to register 0 changes nothing.
- R5: Every read combination not covered by R2 and R4 returns zero, and `rd_data` is zero whenever `rd_en` is low.
- R6: A write to register 5 drives a one-hot `cache_cmd` for exactly the one cycle after the write edge. The bit is chosen by the operation code: 28 gives bit 0 (invalidate both caches), 20 gives bit 1 (invalidate instruction cache), 12 gives bit 2 (invalidate data cache), 10 gives bit 3 (clean data cache), 14 gives bit 4 (flush data cache), 13 gives bit 5 (invalidate one data line), 11 gives bit 6 (clean one data line) and 15 gives bit 7 (flush one data line).
- R7: While a line command (bit 5, 6 or 7) is active, `cache_line_addr` carries the write data of that access. In every other cycle it is zero.
- R8: A write to register 6 with an operation code from 2 to 6 inclusive pulses `tlb_flush_all` for the one cycle after the write edge. Any other code to register 6 gives no pulse.
- R9: A write to register 5 with an operation code not listed in R6 gives no command. A write to any register number above 6 changes no state.
- R10: `acc_err` is high for exactly the one cycle after an unrecognised access. Unrecognised means a write not covered by R2, R6 or R8, or a read not covered by R2 or R4. After a recognised access or an idle cycle it is low.
- R11: `irq_accept` equals `irq_req` AND NOT `irq_disable`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Move-to-coprocessor write strobe, one cycle per access |
| rd_en | input | 1 | Move-from-coprocessor read strobe |
| reg_num | input | REG_W (4) | Register number |
| op_code | input | OP_W (9) | Operation code |
| wr_data | input | DATA_W (32) | Write data, or line address for line commands |
| rd_data | output | DATA_W (32) | Combinational read data |
| cache_cmd | output | 8 | One-hot cache-maintenance command pulse |
| cache_line_addr | output | DATA_W (32) | Target line address for line commands |
| tlb_flush_all | output | 1 | TLB flush-all command pulse |
| acc_err | output | 1 | One-cycle pulse after an unrecognised access |
| irq_req | input | 1 | Hardware interrupt request from the core |
| irq_disable | input | 1 | Interrupt-disable bit of the core's status word |
| irq_accept | output | 1 | Interrupt may be taken |

## Verification
The hard case is the set of unrecognised operation codes. The legal cache codes are scattered between 10 and 28 inside a 512-value space, and each register accepts a different set of codes, so uniform random codes would almost never land next to a legal one. The random stimulus therefore draws most codes from 0, from the legal cache and TLB codes and from their immediate neighbours, and only rarely from the full range. A directed sweep walks every cache code and every register-6 code from 1 to 7, so each one-hot bit, each edge of the TLB window and the return of every pulse to zero in the following cycle are all seen.

// File: rtl/ctlcop_pkg.sv
package ctlcop_pkg;

  localparam int CMD_N   = 8;
  localparam int HOLD_N  = 4;
  localparam int RN_ID    = 0;
  localparam int RN_FIRST = 1;
  localparam int RN_CACHE = 5;
  localparam int RN_TLB   = 6;
  localparam int TLB_LO   = 2;
  localparam int TLB_HI   = 6;

  typedef enum logic [2:0] {
    CC_INV_BOTH  = 3'd0,
    CC_INV_I     = 3'd1,
    CC_INV_D     = 3'd2,
    CC_CLEAN_D   = 3'd3,
    CC_FLUSH_D   = 3'd4,
    CC_INV_LINE  = 3'd5,
    CC_CLEAN_LN  = 3'd6,
    CC_FLUSH_LN  = 3'd7
  } cache_op_e;

  localparam logic [CMD_N-1:0] LINE_MASK =
    (8'd1 << CC_INV_LINE) | (8'd1 << CC_CLEAN_LN) | (8'd1 << CC_FLUSH_LN);

  function automatic logic [CMD_N-1:0] cache_decode(input logic [31:0] op);
    logic [CMD_N-1:0] v;
    v = '0;
    case (op)
      32'd28: v[CC_INV_BOTH] = 1'b1;
      32'd20: v[CC_INV_I]    = 1'b1;
      32'd12: v[CC_INV_D]    = 1'b1;
      32'd10: v[CC_CLEAN_D]  = 1'b1;
      32'd14: v[CC_FLUSH_D]  = 1'b1;
      32'd13: v[CC_INV_LINE] = 1'b1;
      32'd11: v[CC_CLEAN_LN] = 1'b1;
      32'd15: v[CC_FLUSH_LN] = 1'b1;
      default: v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/ctlcop_store.sv
module ctlcop_store
  import ctlcop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 4,
  parameter int OP_W   = 9,
  parameter logic [DATA_W-1:0] ID_WORD    = '0,
  parameter logic [DATA_W-1:0] CTYPE_WORD = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_W-1:0]  reg_num,
  input  logic [OP_W-1:0]   op_code,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_bad
);

  logic [DATA_W-1:0] hold_q [HOLD_N];
  logic              rd_hit;

  for (genvar i = 0; i < HOLD_N; i++) begin : g_hold
    localparam logic [REG_W-1:0] MY_NUM = REG_W'(RN_FIRST + i);

    always_ff @(posedge clk) begin
      if (rst) begin
        hold_q[i] <= '0;
      end else if (wr_en && reg_num == MY_NUM && op_code == '0) begin
        hold_q[i] <= wr_data;
      end
    end

    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (rst)
      (wr_en && op_code != '0) |=> $stable(hold_q[i]))
      else $error("held word changed on bad op"); // R3
  end

  always_comb begin
    rd_data = '0;
    rd_hit  = 1'b0;
    if (rd_en) begin
      if (reg_num == REG_W'(RN_ID)) begin
        if (op_code == '0) begin
          rd_data = ID_WORD;
          rd_hit  = 1'b1;
        end else if (op_code == OP_W'(1)) begin
          rd_data = CTYPE_WORD;
          rd_hit  = 1'b1;
        end
      end else if (op_code == '0) begin
        for (int k = 0; k < HOLD_N; k++) begin
          if (reg_num == REG_W'(RN_FIRST + k)) begin
            rd_data = hold_q[k];
            rd_hit  = 1'b1;
          end
        end
      end
    end
  end

  assign rd_bad = rd_en && !rd_hit;

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_en |-> rd_data == '0)
    else $error("read data nonzero while idle"); // R5

endmodule

// File: rtl/ctlcop_cmd_dec.sv
module ctlcop_cmd_dec
  import ctlcop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 4,
  parameter int OP_W   = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  reg_num,
  input  logic [OP_W-1:0]   op_code,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CMD_N-1:0]  cache_cmd_q,
  output logic [DATA_W-1:0] line_addr_q,
  output logic              tlb_q,
  output logic              wr_bad
);

  logic [CMD_N-1:0]  cmd_d;
  logic [DATA_W-1:0] line_d;
  logic              tlb_d;
  logic              hold_hit;

  always_comb begin
    hold_hit = wr_en && op_code == '0 &&
               reg_num >= REG_W'(RN_FIRST) &&
               reg_num <= REG_W'(RN_FIRST + HOLD_N - 1);
    cmd_d    = (wr_en && reg_num == REG_W'(RN_CACHE)) ?
               cache_decode(32'(op_code)) : '0;
    tlb_d    = wr_en && reg_num == REG_W'(RN_TLB) &&
               op_code >= OP_W'(TLB_LO) && op_code <= OP_W'(TLB_HI);
    line_d   = (|(cmd_d & LINE_MASK)) ? wr_data : '0;
    wr_bad   = wr_en && !(hold_hit || (|cmd_d) || tlb_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cache_cmd_q <= '0;
      line_addr_q <= '0;
      tlb_q       <= 1'b0;
    end else begin
      cache_cmd_q <= cmd_d;
      line_addr_q <= line_d;
      tlb_q       <= tlb_d;
    end
  end

  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cache_cmd_q))
    else $error("cache command not one-hot"); // R6

  AST_CMD_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (|cache_cmd_q) |-> $past(wr_en))
    else $error("cache command without write"); // R6

  AST_LINE_ADDR_GATED: assert property (@(posedge clk) disable iff (rst)
    (line_addr_q != '0) |-> (|(cache_cmd_q & LINE_MASK)))
    else $error("line address outside line command"); // R7

  AST_TLB_ALONE: assert property (@(posedge clk) disable iff (rst)
    tlb_q |-> (cache_cmd_q == '0 && $past(wr_en)))
    else $error("tlb pulse overlaps cache command"); // R8

endmodule

// File: rtl/ctlcop_err.sv
module ctlcop_err (
  input  logic clk,
  input  logic rst,
  input  logic rd_bad,
  input  logic wr_bad,
  input  logic irq_req,
  input  logic irq_disable,
  output logic err_q,
  output logic irq_accept
);

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= rd_bad | wr_bad;
  end

  assign irq_accept = irq_req & ~irq_disable;

endmodule

// File: rtl/ctlcop_regfile.sv
module ctlcop_regfile
  import ctlcop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 4,
  parameter int OP_W   = 9,
  parameter logic [DATA_W-1:0] ID_WORD    = 32'h4D11_0863,
  parameter logic [DATA_W-1:0] CTYPE_WORD = 32'h0D17_2192
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_W-1:0]  reg_num,
  input  logic [OP_W-1:0]   op_code,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [CMD_N-1:0]  cache_cmd,
  output logic [DATA_W-1:0] cache_line_addr,
  output logic              tlb_flush_all,
  output logic              acc_err,
  input  logic              irq_req,
  input  logic              irq_disable,
  output logic              irq_accept
);

  logic rd_bad;
  logic wr_bad;

  ctlcop_store #(
    .DATA_W(DATA_W), .REG_W(REG_W), .OP_W(OP_W),
    .ID_WORD(ID_WORD), .CTYPE_WORD(CTYPE_WORD)
  ) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .reg_num(reg_num), .op_code(op_code), .wr_data(wr_data),
    .rd_data(rd_data), .rd_bad(rd_bad)
  );

  ctlcop_cmd_dec #(
    .DATA_W(DATA_W), .REG_W(REG_W), .OP_W(OP_W)
  ) u_cmd (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .reg_num(reg_num), .op_code(op_code), .wr_data(wr_data),
    .cache_cmd_q(cache_cmd), .line_addr_q(cache_line_addr),
    .tlb_q(tlb_flush_all), .wr_bad(wr_bad)
  );

  ctlcop_err u_err (
    .clk(clk), .rst(rst), .rd_bad(rd_bad), .wr_bad(wr_bad),
    .irq_req(irq_req), .irq_disable(irq_disable),
    .err_q(acc_err), .irq_accept(irq_accept)
  );

  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && rd_en))
    else $error("read and write in one cycle"); // R10

  AST_ERR_AFTER_ACCESS: assert property (@(posedge clk) disable iff (rst)
    acc_err |-> $past(wr_en || rd_en))
    else $error("error pulse without access"); // R10

  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (rst)
    irq_accept |-> (irq_req && !irq_disable))
    else $error("interrupt taken while disabled"); // R11

endmodule

// File: tb/ctlcop_regfile_tb.sv
module ctlcop_regfile_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int RW = 4;
  localparam int OW = 9;
  localparam logic [31:0] P_ID    = 32'hA5C3_0001;
  localparam logic [31:0] P_CTYPE = 32'h1234_8765;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [RW-1:0] reg_num = '0;
  logic [OW-1:0] op_code = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [7:0]    cache_cmd;
  logic [DW-1:0] cache_line_addr;
  logic          tlb_flush_all, acc_err;
  logic          irq_req = 1'b0, irq_disable = 1'b0, irq_accept;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] m_hold [1:4];

  always #(CLK_PERIOD/2) clk = ~clk;

  ctlcop_regfile #(
    .DATA_W(DW), .REG_W(RW), .OP_W(OW), .ID_WORD(P_ID), .CTYPE_WORD(P_CTYPE)
  ) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .reg_num(reg_num), .op_code(op_code), .wr_data(wr_data),
    .rd_data(rd_data), .cache_cmd(cache_cmd), .cache_line_addr(cache_line_addr),
    .tlb_flush_all(tlb_flush_all), .acc_err(acc_err),
    .irq_req(irq_req), .irq_disable(irq_disable), .irq_accept(irq_accept)
  );

  function automatic logic [7:0] exp_cmd(input int r, input int o);
    if (r != 5) return 8'h00;
    case (o)
      28: return 8'h01;
      20: return 8'h02;
      12: return 8'h04;
      10: return 8'h08;
      14: return 8'h10;
      13: return 8'h20;
      11: return 8'h40;
      15: return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit exp_tlb(input int r, input int o);
    return (r == 6) && (o >= 2) && (o <= 6);
  endfunction

  function automatic bit exp_wr_err(input int r, input int o);
    bit ok;
    ok = (r >= 1 && r <= 4 && o == 0) || (exp_cmd(r, o) != 0) || exp_tlb(r, o);
    return !ok;
  endfunction

  function automatic bit exp_rd_err(input int r, input int o);
    return !((r == 0 && o <= 1) || (r >= 1 && r <= 4 && o == 0));
  endfunction

  function automatic logic [31:0] exp_rd(input int r, input int o);
    if (r == 0 && o == 0) return P_ID;
    if (r == 0 && o == 1) return P_CTYPE;
    if (r >= 1 && r <= 4 && o == 0) return m_hold[r];
    return 32'h0;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input int r, input int o, input logic [31:0] d);
    logic [7:0] ec;
    ec = exp_cmd(r, o);
    @(negedge clk);
    wr_en = 1'b1; reg_num = RW'(r); op_code = OW'(o); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    chk("R6", "cache_cmd", 32'(cache_cmd), 32'(ec));
    chk("R7", "line_addr", cache_line_addr, (ec & 8'hE0) != 0 ? d : 32'h0);
    chk("R8", "tlb_flush", 32'(tlb_flush_all), 32'(exp_tlb(r, o)));
    chk("R10", "wr err", 32'(acc_err), 32'(exp_wr_err(r, o)));
    if (r >= 1 && r <= 4 && o == 0) m_hold[r] = d;
    @(negedge clk);
    #1;
    chk("R6", "cmd cleared", 32'(cache_cmd), 32'h0);
    chk("R8", "tlb cleared", 32'(tlb_flush_all), 32'h0);
    chk("R10", "err cleared", 32'(acc_err), 32'h0);
  endtask

  task automatic do_read(input int r, input int o, input string req);
    @(negedge clk);
    rd_en = 1'b1; reg_num = RW'(r); op_code = OW'(o);
    #1;
    chk(req, "rd_data", rd_data, exp_rd(r, o));
    @(negedge clk);
    rd_en = 1'b0;
    #1;
    chk("R10", "rd err", 32'(acc_err), 32'(exp_rd_err(r, o)));
    chk("R5", "idle rd_data", rd_data, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 1; i <= 4; i++) m_hold[i] = 32'h0;
    void'($urandom(32'h5EED_C0DE));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1", "cmd at reset", 32'(cache_cmd), 32'h0);
    chk("R1", "tlb at reset", 32'(tlb_flush_all), 32'h0);
    chk("R1", "err at reset", 32'(acc_err), 32'h0);
    for (int i = 1; i <= 4; i++) do_read(i, 0, "R1");

    // R2 store and read back
    do_write(1, 0, 32'hDEAD_BEEF);
    do_write(2, 0, 32'h0000_4000);
    do_write(3, 0, 32'h0000_00F5);
    do_write(4, 0, 32'hC000_1230);
    for (int i = 1; i <= 4; i++) do_read(i, 0, "R2");

    // R3 bad op to held registers
    do_write(2, 3, 32'h1111_1111);
    do_write(4, 1, 32'h2222_2222);
    do_read(2, 0, "R3");
    do_read(4, 0, "R3");
    do_read(2, 1, "R3");

    // R4 fixed words, write to register 0 rejected
    do_read(0, 0, "R4");
    do_read(0, 1, "R4");
    do_write(0, 0, 32'hFFFF_FFFF);
    do_read(0, 0, "R4");
    do_read(0, 2, "R5");
    do_read(5, 0, "R5");
    do_read(6, 3, "R5");

    // R6 R7 every cache code
    do_write(5, 28, 32'h0);
    do_write(5, 20, 32'h0);
    do_write(5, 12, 32'h0);
    do_write(5, 10, 32'h0);
    do_write(5, 14, 32'h0);
    do_write(5, 13, 32'h0000_8040);
    do_write(5, 11, 32'h0001_0020);
    do_write(5, 15, 32'hFFFF_FFE0);

    // R9 unlisted cache codes and high register numbers
    do_write(5, 0, 32'h5);
    do_write(5, 16, 32'h5);
    do_write(5, 29, 32'h5);
    do_write(7, 0, 32'h77);
    do_write(15, 0, 32'h77);
    for (int i = 1; i <= 4; i++) do_read(i, 0, "R9");

    // R8 TLB window edges
    for (int o = 1; o <= 7; o++) do_write(6, o, 32'h0);

    // R11 interrupt gate
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      irq_req = i[0]; irq_disable = i[1];
      #1;
      chk("R11", "irq_accept", 32'(irq_accept), 32'(i[0] && !i[1]));
    end
    irq_req = 1'b0; irq_disable = 1'b0;

    // random mix biased to near-legal codes
    for (int n = 0; n < 400; n++) begin
      int r, o, pick;
      logic [31:0] d;
      pick = int'($urandom_range(0, 9));
      r = int'($urandom_range(0, 8));
      if (pick < 4)       o = 0;
      else if (pick < 8)  o = int'($urandom_range(0, 30));
      else                o = int'($urandom_range(0, 511));
      d = $urandom;
      if ($urandom_range(0, 1) == 1) do_write(r, o, d);
      else do_read(r, o, (r == 0) ? "R4" : "R2");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule